// File: doc/BRIEF.md
# Rising-Edge Interrupt Cause Collector

This block watches a vector of live status flags coming from a serial-flash controller and turns each low-to-high change of a flag into a sticky cause bit. Software reads the cause vector, acknowledges a cause by writing a 1 to its bit position, and chooses which causes may drive the single interrupt request through a mask register. A flag that merely stays high does not re-arm its cause. Software must therefore sample the live flags before it arms the mask, because a condition that is already true produces no new edge.

Cause bits are recorded whether or not they are masked. The interrupt request is held in a two-state controller. `IRQ_QUIET` moves to `IRQ_RAISED` when the next cause and mask values share a set bit. `IRQ_RAISED` returns to `IRQ_QUIET` when they no longer do, whether because software cleared the cause or because it masked the bit. Both states otherwise hold. Because the next state is taken from the next register values, the request always agrees with the cause and mask registers in the same cycle.

Top module: `edge_irq_cause_unit`

## Requirements
- R1: When a status flag is 0 in one cycle and 1 in the next, its cause bit is 1 from the following clock edge on.
- R2: A flag that stays high, or that falls, sets nothing. After its cause is cleared, a flag held high leaves the cause at 0.
- R3: Asserting `cause_clr_we` clears every cause bit whose `cause_clr_bits` bit is 1 and leaves the bits written as 0 unchanged. All ones clears every cause.
- R4: If a rising edge and a clear of the same bit arrive in one cycle, the cause bit ends up set.
- R5: Asserting `mask_we` loads `mask_wdata` into the mask, which is readable on `mask_o` from the next edge.
- R6: `irq_o` is 1 exactly when some bit is 1 in both `cause_o` and `mask_o`. An all-zero mask keeps `irq_o` at 0.
- R7: Causes latch while masked. Writing a mask that covers a pending cause raises `irq_o` in the same cycle that `mask_o` shows the new mask.
- R8: Reset clears the mask, all causes and `irq_o`. A flag that is already high when reset is released is not an edge.
- R9: Flag positions: bit 12 address missing; bit 11 write-FIFO overflow; bit 10 write-FIFO underflow; bit 9 read-FIFO overflow; bit 8 read-FIFO underflow; bit 7 write-FIFO full; bit 6 write-FIFO empty; bit 5 read-FIFO full; bit 4 read-FIFO empty; bit 3 write-FIFO ready; bit 2 read-FIFO ready; bit 1 transfer ready; bit 0 transfer done. Each position behaves independently per R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 13 | Live status flags (positions per R9) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 13 | New mask value |
| cause_clr_we | input | 1 | Cause write-1-to-clear strobe |
| cause_clr_bits | input | 13 | Bits to clear |
| cause_o | output | 13 | Current cause vector |
| mask_o | output | 13 | Current mask vector |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle:
- the request matches the AND of cause and mask;
- a detected edge always lands in its cause bit, even when a clear targets the same bit;
- a clear with no competing edge empties its bits;
- no cause bit rises without an edge;
- a mask write loads the mask;
- unmasking a pending cause raises the request on the next edge.

Only the bench scenarios can show the remaining behaviours:
- the edge-versus-level distinction seen from the pins, namely a held flag after a clear, a falling flag, and a flag already high at reset release;
- the position of each flag in the vector;
- the outcome of mixed patterns of flags, masks and clears.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int IC_NUM_FLAGS = 13;

    // Flag positions within the status vector
    localparam int IC_XFER_DONE   = 0;
    localparam int IC_XFER_READY  = 1;
    localparam int IC_RD_READY    = 2;
    localparam int IC_WR_READY    = 3;
    localparam int IC_RD_EMPTY    = 4;
    localparam int IC_RD_FULL     = 5;
    localparam int IC_WR_EMPTY    = 6;
    localparam int IC_WR_FULL     = 7;
    localparam int IC_RD_UNDER    = 8;
    localparam int IC_RD_OVER     = 9;
    localparam int IC_WR_UNDER    = 10;
    localparam int IC_WR_OVER     = 11;
    localparam int IC_ADDR_MISS   = 12;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/ic_edge_detect.sv
module ic_edge_detect #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Previous value resets high: a flag already set at reset release is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= flags_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise_o[g] = flags_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/ic_cause_reg.sv
module ic_cause_reg #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] cause_d_o,
    output logic [W-1:0] cause_q_o
);
    logic [W-1:0] clear_sel;

    always_comb begin
        clear_sel = clr_we_i ? clr_bits_i : '0;
        // Set has priority over a simultaneous clear
        cause_d_o = (cause_q_o & ~clear_sel) | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q_o <= '0;
        else        cause_q_o <= cause_d_o;
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((cause_q_o & $past(rise_i)) == $past(rise_i))); // R1

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && ((clr_bits_i & rise_i) != '0)) |=> ((cause_q_o & $past(clr_bits_i & rise_i)) != '0)); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((cause_q_o & $past(clr_bits_i & ~rise_i)) == '0)); // R3

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q_o & ~$past(cause_q_o) & ~$past(rise_i)) == '0)); // R2
endmodule

// File: rtl/ic_irq_ctrl.sv
module ic_irq_ctrl
    import ic_pkg::*;
#(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic [W-1:0] cause_d_i,
    input  logic [W-1:0] cause_q_i,
    output logic [W-1:0] mask_q_o,
    output logic         irq_o
);
    irq_state_e   state_q, state_d;
    logic [W-1:0] mask_d;
    logic         hit_next;

    always_comb begin
        mask_d   = mask_we_i ? mask_wdata_i : mask_q_o;
        hit_next = |(cause_d_i & mask_d);
        state_d  = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (hit_next)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!hit_next) state_d = IRQ_QUIET;
            default:                   state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= IRQ_QUIET;
            mask_q_o <= '0;
        end else begin
            state_q  <= state_d;
            mask_q_o <= mask_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(cause_q_i & mask_q_o))); // R6

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_q_o == $past(mask_wdata_i))); // R5

    AST_UNMASK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && ((cause_d_i & mask_wdata_i) != '0)) |=> irq_o); // R7
endmodule

// File: rtl/edge_irq_cause_unit.sv
module edge_irq_cause_unit
    import ic_pkg::*;
#(
    parameter int NUM_FLAGS = IC_NUM_FLAGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] status_i,
    input  logic                 mask_we,
    input  logic [NUM_FLAGS-1:0] mask_wdata,
    input  logic                 cause_clr_we,
    input  logic [NUM_FLAGS-1:0] cause_clr_bits,
    output logic [NUM_FLAGS-1:0] cause_o,
    output logic [NUM_FLAGS-1:0] mask_o,
    output logic                 irq_o
);
    logic [NUM_FLAGS-1:0] rise;
    logic [NUM_FLAGS-1:0] cause_next;

    ic_edge_detect #(.W(NUM_FLAGS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (status_i),
        .rise_o  (rise)
    );

    ic_cause_reg #(.W(NUM_FLAGS)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .clr_we_i   (cause_clr_we),
        .clr_bits_i (cause_clr_bits),
        .cause_d_o  (cause_next),
        .cause_q_o  (cause_o)
    );

    ic_irq_ctrl #(.W(NUM_FLAGS)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .cause_d_i    (cause_next),
        .cause_q_i    (cause_o),
        .mask_q_o     (mask_o),
        .irq_o        (irq_o)
    );

    AST_FLAG_HELD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr_we && $stable(status_i)) |=> ((cause_o & $past(cause_clr_bits)) == '0)); // R2
endmodule

// File: tb/test_edge_irq_cause_unit.sv
module test_edge_irq_cause_unit;
    localparam int W = 13;
    localparam logic [W-1:0] ALL = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] status_i = '0;
    logic         mask_we = 1'b0;
    logic [W-1:0] mask_wdata = '0;
    logic         cause_clr_we = 1'b0;
    logic [W-1:0] cause_clr_bits = '0;
    logic [W-1:0] cause_o, mask_o;
    logic         irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_cause = '0, m_mask = '0, m_prev = '1;

    always #5 clk = ~clk;

    edge_irq_cause_unit #(.NUM_FLAGS(W)) i_edge_irq_cause_unit (
        .clk(clk), .rst_n(rst_n), .status_i(status_i),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cause_clr_we(cause_clr_we), .cause_clr_bits(cause_clr_bits),
        .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "cause", 32'(cause_o), 32'(m_cause));
        chk(req, "mask",  32'(mask_o),  32'(m_mask));
        chk(req, "irq",   32'(irq_o),   32'(|(m_cause & m_mask)));
    endtask

    // One cycle: drive at negedge, update model at edge, check just after it
    task automatic step(input logic [W-1:0] st, input logic mwe, input logic [W-1:0] md,
                        input logic cwe, input logic [W-1:0] cd, input string req);
        logic [W-1:0] rise;
        @(negedge clk);
        status_i = st; mask_we = mwe; mask_wdata = md;
        cause_clr_we = cwe; cause_clr_bits = cd;
        @(posedge clk);
        #2;
        mask_we = 1'b0; cause_clr_we = 1'b0;
        rise    = st & ~m_prev;
        m_cause = (m_cause & ~(cwe ? cd : '0)) | rise;
        m_prev  = st;
        if (mwe) m_mask = md;
        check_all(req);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: flags high through reset
        status_i = 13'h1005;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R8");
        step(13'h1005, 1'b0, '0, 1'b0, '0, "R8");
        chk("R8", "no edge from reset-high flags", 32'(cause_o), 32'h0);
        step('0, 1'b0, '0, 1'b0, '0, "R2");

        // R1/R9/R2/R3: per-position sweep with mask closed
        for (int b = 0; b < W; b++) begin
            step(W'(1) << b, 1'b0, '0, 1'b0, '0, "R9");
            chk("R1", "edge sets its own bit", 32'(cause_o), 32'(1) << b);
            chk("R6", "zero mask blocks irq", 32'(irq_o), 32'h0);
            step(W'(1) << b, 1'b0, '0, 1'b1, W'(1) << b, "R3");
            step(W'(1) << b, 1'b0, '0, 1'b0, '0, "R2");
            chk("R2", "held flag after clear", 32'(cause_o), 32'h0);
            step('0, 1'b0, '0, 1'b0, '0, "R2");
        end

        // R7: latch all while masked, then unmask one bit at a time
        step(ALL, 1'b0, '0, 1'b0, '0, "R7");
        chk("R7", "all causes latched while masked", 32'(cause_o), 32'(ALL));
        for (int b = 0; b < W; b++) begin
            step(ALL, 1'b1, W'(1) << b, 1'b0, '0, "R7");
            chk("R7", "unmask pending raises irq", 32'(irq_o), 32'h1);
        end
        step(ALL, 1'b0, '0, 1'b1, '0, "R3");
        chk("R3", "write zero keeps causes", 32'(cause_o), 32'(ALL));
        step(ALL, 1'b0, '0, 1'b1, ALL, "R3");
        chk("R3", "all-ones clears", 32'(cause_o), 32'h0);
        chk("R6", "irq drops when cleared", 32'(irq_o), 32'h0);
        step('0, 1'b1, '0, 1'b0, '0, "R5");

        // R4: edge and clear of same bit together
        for (int b = 0; b < W; b++) begin
            step(W'(1) << b, 1'b0, '0, 1'b1, ALL, "R4");
            chk("R4", "set wins over clear", 32'(cause_o), 32'(1) << b);
            step('0, 1'b0, '0, 1'b1, ALL, "R4");
        end

        // R5/R6: mixed patterns computed arithmetically
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] st, md, cd;
            st = W'((i * 613) ^ (i << 3));
            md = W'((i * 2753) >> 2);
            cd = W'(i * 97 + 5);
            step(st, (i % 3) == 0, md, (i % 4) == 1, cd, (i % 2) ? "R6" : "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule